// File: doc/BRIEF.md
# Router Flit History Recorder

This block sits next to a mesh network router and keeps a rolling trace of the flits that cross it. It watches the valid/ready handshake on every router input port and on the local egress port. Each of these links has its own fixed-depth history. Every accepted flit is copied into the history of the link it crossed, together with its virtual channel number and its flit type. A packet that enters on one port and leaves locally therefore shows up in two histories, which helps narrow down which stage corrupted or lost it.

Capture is purely passive and needs nothing from the processors. After a hang, the network adapter reads the traces through a dedicated read port that does not depend on any core running. A freeze input stops all capture so that a coherent snapshot can be read out. A clear input empties every history.

Top module: `flit_history_recorder`

## Requirements
- R1: After reset every history is empty: a read of any entry returns rd_ok=0 and rd_data=0, and rd_valid is low while reset is held.
- R2: A flit on input port p is recorded only in a cycle where in_valid[p] and in_ready[p] are both high. It becomes entry 0 of history p. A valid flit without ready is not recorded.
- R3: The local egress is history index NUM_IN. It records on out_valid and out_ready in the same way as the input ports.
- R4: Each record pushes the earlier ones one place deeper, so entry k holds the (k+1)-th most recent flit. Once DEPTH flits are held, a new record discards the oldest one.
- R5: Each history keeps a fill count that saturates at DEPTH. A read reports rd_ok=1 only for an entry index below that count. Reads of unfilled entries return rd_ok=0 and rd_data=0.
- R6: A record is packed as {flit type, virtual channel, flit} and split into 32-bit words, with word 0 holding bits 31:0. With a 32-bit flit and a 2-bit VC, word 1 holds the VC in bits 1:0, the type in bits 3:2, and zeros above. Type codes are head=0, body=1, tail=2, single-flit (head and tail)=3.
- R7: rd_addr is {history index, entry index, word select}, with the word select in the low bit(s). A request on rd_en is answered one cycle later with rd_valid high for exactly one cycle.
- R8: While freeze is high no history records anything, whatever the port handshakes do. Once freeze is low again, recording resumes.
- R9: A clear pulse empties every history. A handshake in the same cycle as clear is not recorded, and clear takes effect even while frozen.
- R10: When a read and a record on the same history fall in the same cycle, the read returns the contents from before that record.
- R11: A history index of NUM_IN+1 or above, or an entry index of DEPTH or above, returns rd_ok=0 and rd_data=0.
- R12: The histories are independent. One flit accepted on several ports in the same cycle appears as entry 0 of each of those histories.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_IN | Valid of each router input port |
| in_ready | input | NUM_IN | Ready of each router input port |
| in_flit | input | NUM_IN*FLIT_W | Flit payload of each input port |
| in_vc | input | NUM_IN*VC_W | Virtual channel of each input port |
| in_ftype | input | NUM_IN*2 | Flit type of each input port |
| out_valid | input | 1 | Valid of the local egress port |
| out_ready | input | 1 | Ready of the local egress port |
| out_flit | input | FLIT_W | Flit payload on the local egress |
| out_vc | input | VC_W | Virtual channel on the local egress |
| out_ftype | input | 2 | Flit type on the local egress |
| freeze | input | 1 | Holds all histories unchanged |
| clear | input | 1 | Empties all histories |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | {history, entry, word} read address |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |
| rd_data | output | 32 | Selected 32-bit word of the entry |
| rd_ok | output | 1 | Addressed entry holds a recorded flit |

## Verification
A table of handshakes spread over all five links, some with ready held low, is replayed against a queue model in the bench. Every word of every entry is then read back. This separates correct per-port routing of records from records landing in the wrong history, and real captures from ignored ones. A long burst into one port pushes it past its depth, which shows whether the oldest entry is dropped and whether the fill count stops at the limit. Directed cases cover simultaneous flits on several ports, a read and a record in the same cycle, freeze, clear together with a handshake, and out-of-range addresses. Each of these shows whether the capture gating and the read path have the intended priority.

// File: rtl/flit_hist_pkg.sv
package flit_hist_pkg;

    localparam int BUS_W   = 32;
    localparam int FTYPE_W = 2;

    typedef enum logic [FTYPE_W-1:0] {
        FT_HEAD   = 2'd0,
        FT_BODY   = 2'd1,
        FT_TAIL   = 2'd2,
        FT_SINGLE = 2'd3
    } ftype_e;

    // Index width for n selectable items, never below one bit
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Number of bus words needed to carry w bits
    function automatic int bus_words(input int w);
        return (w + BUS_W - 1) / BUS_W;
    endfunction

endpackage

// File: rtl/flit_hist_lane.sv
module flit_hist_lane #(
    parameter int DEPTH = 64,
    parameter int REC_W = 36,
    parameter int CNT_W = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cap,
    input  logic                        clr,
    input  logic [REC_W-1:0]            rec_in,
    output logic [DEPTH-1:0][REC_W-1:0] hist_o,
    output logic [CNT_W-1:0]            cnt_o
);

    logic [DEPTH-1:0][REC_W-1:0] hist_q;
    logic [CNT_W-1:0]            cnt_q;

    // Fill count, saturating at the depth
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (cap && (cnt_q != CNT_W'(DEPTH))) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Storage: index 0 is newest
    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (cap && !clr) begin
                    hist_q[0] <= rec_in;
                end
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (cap && !clr) begin
                    hist_q <= {hist_q[DEPTH-2:0], rec_in};
                end
            end
        end
    endgenerate

    assign hist_o = hist_q;
    assign cnt_o  = cnt_q;

endmodule

// File: rtl/flit_hist_readmux.sv
module flit_hist_readmux
    import flit_hist_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int DEPTH  = 64,
    parameter int REC_W  = 36,
    parameter int CNT_W  = 7,
    parameter int PORT_W = 3,
    parameter int IDX_W  = 6,
    parameter int WORDS  = 2,
    parameter int WSEL_W = 1,
    localparam int ADDR_W = PORT_W + IDX_W + WSEL_W,
    localparam int PAD_W  = WORDS * BUS_W
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [NPORT-1:0][DEPTH-1:0][REC_W-1:0] hist,
    input  logic [NPORT-1:0][CNT_W-1:0]            cnt,
    input  logic                                   rd_en,
    input  logic [ADDR_W-1:0]                      rd_addr,
    output logic                                   rd_valid,
    output logic [BUS_W-1:0]                       rd_data,
    output logic                                   rd_ok
);

    logic [PORT_W-1:0] a_port;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_word;
    logic              hit;
    logic              sel_ok;
    logic [REC_W-1:0]  sel_rec;
    logic [PAD_W-1:0]  padded;
    logic [BUS_W-1:0]  sel_word;

    always_comb begin
        a_port = rd_addr[ADDR_W-1 -: PORT_W];
        a_idx  = rd_addr[WSEL_W +: IDX_W];
        a_word = rd_addr[WSEL_W-1:0];
        hit    = (int'(a_port) < NPORT) && (int'(a_idx) < DEPTH) &&
                 (int'(a_word) < WORDS);
        sel_rec = '0;
        sel_ok  = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (hit && (a_port == PORT_W'(p)) && (a_idx == IDX_W'(e))) begin
                    sel_rec = hist[p][e];
                    sel_ok  = (CNT_W'(e) < cnt[p]);
                end
            end
        end
        padded   = PAD_W'(sel_rec);
        sel_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (a_word == WSEL_W'(w)) begin
                sel_word = padded[w*BUS_W +: BUS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_ok    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= sel_ok ? sel_word : '0;
                rd_ok   <= sel_ok;
            end
        end
    end

endmodule

// File: rtl/flit_history_recorder.sv
module flit_history_recorder
    import flit_hist_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int DEPTH  = 64,
    parameter int FLIT_W = 32,
    parameter int VC_W   = 2,
    localparam int NPORT  = NUM_IN + 1,
    localparam int REC_W  = FLIT_W + VC_W + FTYPE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PORT_W = idx_bits(NPORT),
    localparam int IDX_W  = idx_bits(DEPTH),
    localparam int WORDS  = bus_words(REC_W),
    localparam int WSEL_W = idx_bits(WORDS),
    localparam int ADDR_W = PORT_W + IDX_W + WSEL_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_IN-1:0]                 in_valid,
    input  logic [NUM_IN-1:0]                 in_ready,
    input  logic [NUM_IN-1:0][FLIT_W-1:0]     in_flit,
    input  logic [NUM_IN-1:0][VC_W-1:0]       in_vc,
    input  logic [NUM_IN-1:0][FTYPE_W-1:0]    in_ftype,
    input  logic                              out_valid,
    input  logic                              out_ready,
    input  logic [FLIT_W-1:0]                 out_flit,
    input  logic [VC_W-1:0]                   out_vc,
    input  logic [FTYPE_W-1:0]                out_ftype,
    input  logic                              freeze,
    input  logic                              clear,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic                              rd_valid,
    output logic [BUS_W-1:0]                  rd_data,
    output logic                              rd_ok
);

    logic                                   cap_en;
    logic [NPORT-1:0]                       take;
    logic [NPORT-1:0][REC_W-1:0]            rec;
    logic [NPORT-1:0][DEPTH-1:0][REC_W-1:0] hist;
    logic [NPORT-1:0][CNT_W-1:0]            cnt;

    // Clear wins over capture; freeze blocks capture
    assign cap_en = !freeze && !clear;

    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_in
            assign take[g] = in_valid[g] && in_ready[g] && cap_en;
            assign rec[g]  = {in_ftype[g], in_vc[g], in_flit[g]};
        end
    endgenerate

    assign take[NUM_IN] = out_valid && out_ready && cap_en;
    assign rec[NUM_IN]  = {out_ftype, out_vc, out_flit};

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_lane
            flit_hist_lane #(
                .DEPTH (DEPTH),
                .REC_W (REC_W),
                .CNT_W (CNT_W)
            ) u_lane (
                .clk    (clk),
                .rst    (rst),
                .cap    (take[g]),
                .clr    (clear),
                .rec_in (rec[g]),
                .hist_o (hist[g]),
                .cnt_o  (cnt[g])
            );
        end
    endgenerate

    flit_hist_readmux #(
        .NPORT  (NPORT),
        .DEPTH  (DEPTH),
        .REC_W  (REC_W),
        .CNT_W  (CNT_W),
        .PORT_W (PORT_W),
        .IDX_W  (IDX_W),
        .WORDS  (WORDS),
        .WSEL_W (WSEL_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .hist     (hist),
        .cnt      (cnt),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_ok    (rd_ok)
    );

endmodule

// File: rtl/flit_history_recorder_chk.sv
module flit_history_recorder_chk #(
    parameter int NPORT = 5,
    parameter int CNT_W = 7,
    parameter int DEPTH = 64
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        freeze,
    input logic                        clear,
    input logic                        rd_en,
    input logic                        rd_valid,
    input logic [NPORT-1:0][CNT_W-1:0] cnt
);

    // R7: every request is answered on the next cycle
    p_rd_answer_r7: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R7: no response without a request
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            // R5: fill count never passes the depth
            p_count_cap_r5: assert property (@(posedge clk) disable iff (rst)
                cnt[p] <= CNT_W'(DEPTH));

            // R4: at most one record per history per cycle
            p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
                !clear |=> (cnt[p] == $past(cnt[p])) ||
                           (cnt[p] == $past(cnt[p]) + CNT_W'(1)));

            // R8: frozen histories stay put
            p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
                (freeze && !clear) |=> $stable(cnt[p]));

            // R9: clear empties every history
            p_clear_empty_r9: assert property (@(posedge clk) disable iff (rst)
                clear |=> (cnt[p] == '0));
        end
    endgenerate

endmodule

bind flit_history_recorder flit_history_recorder_chk #(
    .NPORT (NPORT),
    .CNT_W (CNT_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .freeze   (freeze),
    .clear    (clear),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .cnt      (cnt)
);

// File: tb/flit_history_recorder_test.sv
`timescale 1ns/1ps
module flit_history_recorder_test;
    import flit_hist_pkg::*;

    localparam int NUM_IN = 4;
    localparam int DEPTH  = 8;
    localparam int FLIT_W = 32;
    localparam int VC_W   = 2;
    localparam int NPORT  = NUM_IN + 1;
    localparam int ADDR_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_IN-1:0]              in_valid = '0;
    logic [NUM_IN-1:0]              in_ready = '0;
    logic [NUM_IN-1:0][FLIT_W-1:0]  in_flit  = '0;
    logic [NUM_IN-1:0][VC_W-1:0]    in_vc    = '0;
    logic [NUM_IN-1:0][1:0]         in_ftype = '0;
    logic              out_valid = 1'b0;
    logic              out_ready = 1'b0;
    logic [FLIT_W-1:0] out_flit  = '0;
    logic [VC_W-1:0]   out_vc    = '0;
    logic [1:0]        out_ftype = '0;
    logic              freeze = 1'b0;
    logic              clear  = 1'b0;
    logic              rd_en  = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic              rd_ok;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;

    logic [35:0] mdl [NPORT][DEPTH];
    int          mcnt [NPORT];

    always #2 clk = ~clk;

    flit_history_recorder #(
        .NUM_IN (NUM_IN),
        .DEPTH  (DEPTH),
        .FLIT_W (FLIT_W),
        .VC_W   (VC_W)
    ) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
        .in_vc(in_vc), .in_ftype(in_ftype),
        .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
        .out_vc(out_vc), .out_ftype(out_ftype),
        .freeze(freeze), .clear(clear),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ok(rd_ok)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            nfail++;
            $display("FAIL watchdog: got cycle %0d expected finish earlier", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    typedef struct packed {
        logic [2:0]  port;
        logic [31:0] flit;
        logic [1:0]  vc;
        logic [1:0]  ty;
        logic        rdy;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{3'd0, 32'hA000_0001, 2'd1, FT_HEAD,   1'b1},
        '{3'd1, 32'hB000_0002, 2'd2, FT_SINGLE, 1'b1},
        '{3'd0, 32'hA000_0003, 2'd1, FT_BODY,   1'b1},
        '{3'd2, 32'hC000_0004, 2'd3, FT_HEAD,   1'b0},
        '{3'd4, 32'hE000_0005, 2'd0, FT_HEAD,   1'b1},
        '{3'd0, 32'hA000_0006, 2'd1, FT_TAIL,   1'b1},
        '{3'd3, 32'hD000_0007, 2'd2, FT_BODY,   1'b1},
        '{3'd4, 32'hE000_0008, 2'd0, FT_BODY,   1'b0},
        '{3'd4, 32'hE000_0009, 2'd0, FT_TAIL,   1'b1},
        '{3'd2, 32'hC000_000A, 2'd3, FT_SINGLE, 1'b1},
        '{3'd1, 32'hB000_000B, 2'd0, FT_HEAD,   1'b0},
        '{3'd3, 32'h5A5A_A5A5, 2'd1, FT_TAIL,   1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push(input int p, input logic [35:0] r);
        for (int k = DEPTH - 1; k > 0; k--) mdl[p][k] = mdl[p][k-1];
        mdl[p][0] = r;
        if (mcnt[p] < DEPTH) mcnt[p]++;
    endtask

    task automatic drive(input int p, input logic [31:0] f, input logic [1:0] vc,
                         input logic [1:0] ty, input logic rdy);
        if (p < NUM_IN) begin
            in_valid[p] = 1'b1; in_ready[p] = rdy;
            in_flit[p] = f; in_vc[p] = vc; in_ftype[p] = ty;
        end else begin
            out_valid = 1'b1; out_ready = rdy;
            out_flit = f; out_vc = vc; out_ftype = ty;
        end
        if (rdy && !freeze && !clear) push(p, {ty, vc, f});
    endtask

    task automatic idle_all();
        in_valid = '0; in_ready = '0; out_valid = 1'b0; out_ready = 1'b0;
    endtask

    task automatic capture(input int p, input logic [31:0] f, input logic [1:0] vc,
                           input logic [1:0] ty, input logic rdy);
        drive(p, f, vc, ty, rdy);
        @(negedge clk);
        idle_all();
    endtask

    task automatic rd(input int p, input int e, input int w,
                      output logic [31:0] d, output logic ok, output logic v);
        rd_en = 1'b1;
        rd_addr = {3'(p), 3'(e), 1'(w)};
        @(negedge clk);
        d = rd_data; ok = rd_ok; v = rd_valid;
        rd_en = 1'b0;
    endtask

    task automatic check_entry(input string tag, input int p, input int e);
        logic [31:0] d;
        logic ok, v, eok;
        eok = (e < mcnt[p]);
        rd(p, e, 0, d, ok, v);
        chk("R7 rd_valid", 32'(v), 32'd1);
        chk({tag, " ok"}, 32'(ok), 32'(eok));
        chk({tag, " word0"}, d, eok ? mdl[p][e][31:0] : 32'd0);
        rd(p, e, 1, d, ok, v);
        chk({tag, " ok"}, 32'(ok), 32'(eok));
        chk({tag, " word1"}, d, eok ? {28'd0, mdl[p][e][35:32]} : 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        logic ok, v;
        for (int p = 0; p < NPORT; p++) mcnt[p] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rd_valid in reset", 32'(rd_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < NPORT; p++) check_entry("R1 empty", p, 0);

        // Table walk: R2 R3 R6 R12 per-port routing
        for (int i = 0; i < 12; i++)
            capture(int'(VEC[i].port), VEC[i].flit, VEC[i].vc, VEC[i].ty, VEC[i].rdy);
        for (int p = 0; p < NPORT; p++)
            for (int e = 0; e < DEPTH; e++)
                check_entry("R2 R3 R6 table", p, e);

        // R12: same flit on several links at once
        drive(0, 32'h7777_0000, 2'd3, FT_HEAD, 1'b1);
        drive(3, 32'h7777_0000, 2'd3, FT_HEAD, 1'b1);
        drive(4, 32'h7777_0000, 2'd3, FT_HEAD, 1'b1);
        @(negedge clk);
        idle_all();
        check_entry("R12 port0", 0, 0);
        check_entry("R12 port3", 3, 0);
        check_entry("R12 local", 4, 0);

        // R4 R5: overflow port 2
        for (int i = 0; i < 11; i++)
            capture(2, 32'hC0DE_0000 + 32'(i), 2'(i), 2'(i), 1'b1);
        for (int e = 0; e < DEPTH; e++) check_entry("R4 R5 overflow", 2, e);

        // R7: no strobe without request
        @(negedge clk);
        chk("R7 idle", 32'(rd_valid), 32'd0);

        // R10: read and record on same history in same cycle
        begin
            logic [31:0] exp0;
            logic        expok;
            exp0 = mdl[1][0][31:0];
            expok = (mcnt[1] > 0);
            in_valid[1] = 1'b1; in_ready[1] = 1'b1; in_flit[1] = 32'h1010_2020;
            in_vc[1] = 2'd2; in_ftype[1] = FT_TAIL;
            rd_en = 1'b1; rd_addr = {3'd1, 3'd0, 1'b0};
            @(negedge clk);
            d = rd_data; ok = rd_ok;
            rd_en = 1'b0;
            idle_all();
            chk("R10 pre-shift data", d, exp0);
            chk("R10 pre-shift ok", 32'(ok), 32'(expok));
            push(1, {FT_TAIL, 2'd2, 32'h1010_2020});
            check_entry("R10 after", 1, 0);
        end

        // R8: freeze blocks capture, release resumes
        freeze = 1'b1;
        @(negedge clk);
        capture(0, 32'hF0F0_0001, 2'd0, FT_BODY, 1'b1);
        capture(4, 32'hF0F0_0002, 2'd1, FT_BODY, 1'b1);
        for (int e = 0; e < DEPTH; e++) check_entry("R8 frozen port0", 0, e);
        check_entry("R8 frozen local", 4, 0);
        freeze = 1'b0;
        capture(0, 32'hF0F0_0003, 2'd2, FT_TAIL, 1'b1);
        check_entry("R8 resumed", 0, 0);
        check_entry("R8 resumed", 0, 1);

        // R9: clear with a simultaneous handshake
        clear = 1'b1;
        capture(3, 32'hDEAD_0001, 2'd1, FT_HEAD, 1'b1);
        clear = 1'b0;
        for (int p = 0; p < NPORT; p++) mcnt[p] = 0;
        for (int p = 0; p < NPORT; p++) check_entry("R9 cleared", p, 0);
        capture(3, 32'hBEEF_0002, 2'd2, FT_SINGLE, 1'b1);
        check_entry("R9 refill", 3, 0);
        check_entry("R9 refill", 3, 1);

        // R11: history index out of range
        rd(5, 0, 0, d, ok, v);
        chk("R11 port5 ok", 32'(ok), 32'd0);
        chk("R11 port5 data", d, 32'd0);
        rd(7, 3, 1, d, ok, v);
        chk("R11 port7 ok", 32'(ok), 32'd0);
        chk("R11 port7 data", d, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule